// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block is the exception-entry front end of a small 32-bit processor core. It owns the program counter, the stack pointer, the status word with its 4-bit interrupt mask, and the vector base. Coming out of reset it fetches the starting PC and the initial stack pointer over its memory master port. It then waits in an idle state and compares the strongest pending interrupt against the mask.

There are two interrupt sources. One is a 4-bit level from outside the core. The other is a single internal peripheral request, which is captured with its own level and vector and held until it is taken.

When a request wins, the block saves the status word and then the PC on a descending stack. It raises the mask to the accepted level and loads the handler address from a table located at the vector base. For an external request the vector is obtained through a one-cycle acknowledge. An entry cycle counter advances by a fixed cost for each entry. The status word and vector base can be rewritten through simple write strobes, but only while the sequencer is idle.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset is released, the block issues a 32-bit read of address 0 and loads the result into the PC. It then issues a 32-bit read of address 4 and loads the result into the stack pointer. `busy` stays high until both reads complete.
- R2: While reset is held, the status word reads 0x000000F0, so the mask in bits 7:4 is 4'hF. The vector base and the entry cycle counter both read 0.
- R3: An entry starts only when the winning level is strictly greater than the mask, status bits 7:4. With a lower or equal level, `busy`, PC and stack pointer stay unchanged.
- R4: The winning level is the larger of `ext_level` and the level of a captured internal request. On equal levels the internal request wins and no acknowledge is issued.
- R5: A pulse on `int_req` while idle captures `int_level` and `int_vector`. The capture persists until that request is accepted and is cleared on acceptance. `int_req` is ignored while `busy` is high.
- R6: When an external request is accepted, `ack_valid` is high for exactly one cycle with `ack_level` equal to the accepted level. `ack_vector` is sampled in that cycle.
- R7: An entry writes the status word to SP−4 and then the PC to SP−8, in that order. The stack pointer ends at SP−8.
- R8: After the pushes, status bits 7:4 hold the accepted level and every other status bit is unchanged.
- R9: The new PC is the 32-bit value read from address VBR + 4 × vector.
- R10: `cycles` grows by exactly 13 per completed entry and is otherwise unchanged.
- R11: Each memory access is held (valid, address, direction, data) until `mem_ready` is seen high. The sequence advances only on that handshake.
- R12: `sr_we` and `vbr_we` take effect only while idle; writes during reset fetch or an entry are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_level | input | 4 | External interrupt level, 0 = none |
| int_req | input | 1 | Capture strobe for the internal request |
| int_level | input | 4 | Level of the internal request |
| int_vector | input | 8 | Vector number of the internal request |
| ack_valid | output | 1 | Acknowledge strobe for an accepted external request |
| ack_level | output | 4 | Level being acknowledged |
| ack_vector | input | 8 | Vector returned in the acknowledge cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts / completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| sr_we | input | 1 | Status word write strobe |
| sr_wdata | input | 32 | Status word write value |
| vbr_we | input | 1 | Vector base write strobe |
| vbr_wdata | input | 32 | Vector base write value |
| pc | output | 32 | Program counter |
| sp | output | 32 | Stack pointer |
| sr | output | 32 | Status word |
| vbr | output | 32 | Vector base |
| cycles | output | 32 | Entry cycle counter |
| busy | output | 1 | High during reset fetch or interrupt entry |

## Verification
The bench sweeps every mask against every external level, then against internal levels that fall below, tie with and exceed the external one. This catches an off-by-one comparison, which would accept a level equal to the mask. It also catches a reversed tie rule, which would issue a spurious acknowledge. Each entry checks the two stack writes by address and data, so a swapped push order or a wrong stack step shows up as a bad address. A vector table lookup that forgot the ×4 scaling or the base would load the wrong PC. Further targeted cases cover a captured request held under a high mask until the mask drops, strobes ignored during an entry, and a memory that stalls on most cycles; a design that advanced without `mem_ready` would corrupt the stack contents.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
    localparam int XLEN       = 32;
    localparam int LVL_W      = 4;
    localparam int VEC_W      = 8;
    localparam int MASK_LSB   = 4;
    localparam int ENTRY_COST = 13;
    localparam int WORD_BYTES = XLEN / 8;

    localparam logic [XLEN-1:0] SR_AT_RESET   = 32'h0000_00F0;
    localparam logic [XLEN-1:0] BOOT_PC_ADDR  = 32'h0000_0000;
    localparam logic [XLEN-1:0] BOOT_SP_ADDR  = 32'h0000_0004;

    typedef enum logic [2:0] {
        ST_BOOT_PC,
        ST_BOOT_SP,
        ST_IDLE,
        ST_ACK,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } irq_src_t;

    typedef struct packed {
        logic             take;
        logic             from_int;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } grant_t;

    function automatic logic [XLEN-1:0] table_addr(input logic [XLEN-1:0] base,
                                                   input logic [VEC_W-1:0] vec);
        return base + (XLEN'(vec) * XLEN'(WORD_BYTES));
    endfunction
endpackage

// File: rtl/intr_hold.sv
module intr_hold
    import intr_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LVL_W-1:0] load_level,
    input  logic [VEC_W-1:0] load_vector,
    input  logic             clear,
    output irq_src_t         src
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0;
        end else if (load) begin
            src <= '{valid: 1'b1, level: load_level, vector: load_vector};
        end else if (clear) begin
            src.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_pick.sv
module intr_pick
    import intr_entry_pkg::*;
(
    input  logic [LVL_W-1:0] ext_level,
    input  irq_src_t         held,
    input  logic [LVL_W-1:0] mask,
    output grant_t           grant
);
    always_comb begin
        grant = '0;
        if (held.valid && held.level >= ext_level) begin
            grant.from_int = 1'b1;
            grant.level    = held.level;
            grant.vector   = held.vector;
        end else begin
            grant.from_int = 1'b0;
            grant.level    = ext_level;
            grant.vector   = '0;
        end
        grant.take = grant.level > mask;
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] ext_level,
    input  logic             int_req,
    input  logic [LVL_W-1:0] int_level,
    input  logic [VEC_W-1:0] int_vector,
    output logic             ack_valid,
    output logic [LVL_W-1:0] ack_level,
    input  logic [VEC_W-1:0] ack_vector,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             sr_we,
    input  logic [XLEN-1:0]  sr_wdata,
    input  logic             vbr_we,
    input  logic [XLEN-1:0]  vbr_wdata,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  sp,
    output logic [XLEN-1:0]  sr,
    output logic [XLEN-1:0]  vbr,
    output logic [XLEN-1:0]  cycles,
    output logic             busy
);
    seq_state_e       state_q;
    logic [XLEN-1:0]  pc_q, sp_q, sr_q, vbr_q, cyc_q;
    logic [LVL_W-1:0] acc_level_q;
    logic [VEC_W-1:0] acc_vec_q;
    irq_src_t         held;
    grant_t           grant;
    logic             idle, hs;
    logic             lat_valid;
    logic [LVL_W-1:0] lat_level;

    assign idle      = (state_q == ST_IDLE);
    assign hs        = mem_valid && mem_ready;
    assign lat_valid = held.valid;
    assign lat_level = held.level;

    intr_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .load        (idle && int_req),
        .load_level  (int_level),
        .load_vector (int_vector),
        .clear       (idle && grant.take && grant.from_int),
        .src         (held)
    );

    intr_pick u_pick (
        .ext_level (ext_level),
        .held      (held),
        .mask      (sr_q[MASK_LSB +: LVL_W]),
        .grant     (grant)
    );

    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_BOOT_PC: begin
                mem_valid = 1'b1;
                mem_addr  = BOOT_PC_ADDR;
            end
            ST_BOOT_SP: begin
                mem_valid = 1'b1;
                mem_addr  = BOOT_SP_ADDR;
            end
            ST_PUSH_SR: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = sp_q - XLEN'(WORD_BYTES);
                mem_wdata = sr_q;
            end
            ST_PUSH_PC: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = sp_q - XLEN'(WORD_BYTES);
                mem_wdata = pc_q;
            end
            ST_FETCH: begin
                mem_valid = 1'b1;
                mem_addr  = table_addr(vbr_q, acc_vec_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_BOOT_PC;
            pc_q        <= '0;
            sp_q        <= '0;
            sr_q        <= SR_AT_RESET;
            vbr_q       <= '0;
            cyc_q       <= '0;
            acc_level_q <= '0;
            acc_vec_q   <= '0;
        end else begin
            unique case (state_q)
                ST_BOOT_PC: if (hs) begin
                    pc_q    <= mem_rdata;
                    state_q <= ST_BOOT_SP;
                end
                ST_BOOT_SP: if (hs) begin
                    sp_q    <= mem_rdata;
                    state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (sr_we)  sr_q  <= sr_wdata;
                    if (vbr_we) vbr_q <= vbr_wdata;
                    if (grant.take) begin
                        acc_level_q <= grant.level;
                        acc_vec_q   <= grant.vector;
                        state_q     <= grant.from_int ? ST_PUSH_SR : ST_ACK;
                    end
                end
                ST_ACK: begin
                    acc_vec_q <= ack_vector;
                    state_q   <= ST_PUSH_SR;
                end
                ST_PUSH_SR: if (hs) begin
                    sp_q    <= sp_q - XLEN'(WORD_BYTES);
                    state_q <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (hs) begin
                    sp_q                      <= sp_q - XLEN'(WORD_BYTES);
                    sr_q[MASK_LSB +: LVL_W]   <= acc_level_q;
                    state_q                   <= ST_FETCH;
                end
                ST_FETCH: if (hs) begin
                    pc_q    <= mem_rdata;
                    cyc_q   <= cyc_q + XLEN'(ENTRY_COST);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ack_valid = (state_q == ST_ACK);
    assign ack_level = acc_level_q;
    assign pc        = pc_q;
    assign sp        = sp_q;
    assign sr        = sr_q;
    assign vbr       = vbr_q;
    assign cycles    = cyc_q;
    assign busy      = !idle;
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk
    import intr_entry_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             mem_valid,
    input logic             mem_write,
    input logic             mem_ready,
    input logic [XLEN-1:0]  mem_addr,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ext_level,
    input logic             lat_valid,
    input logic [LVL_W-1:0] lat_level,
    input logic [XLEN-1:0]  sr,
    input logic [XLEN-1:0]  sp,
    input logic [XLEN-1:0]  cycles
);
    // R1: first request after reset is a read of the boot PC word
    a_r1_boot_first: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_valid && !mem_write && mem_addr == BOOT_PC_ADDR));

    // R11: request held steady until ready
    a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R7: each completed push lowers the stack pointer by one word
    a_r7_push_step: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_write) |=> (sp == $past(sp) - XLEN'(WORD_BYTES)));

    // R10: counter only moves in steps of the entry cost
    a_r10_cost_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(cycles) |-> (cycles == $past(cycles) + XLEN'(ENTRY_COST)));

    // R3: an entry starts only from a level above the mask
    a_r3_above_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (($past(ext_level) > $past(sr[MASK_LSB +: LVL_W])) ||
                         ($past(lat_valid) && $past(lat_level) > $past(sr[MASK_LSB +: LVL_W]))));

    // R6: acknowledge is a single-cycle strobe
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ack_valid);
endmodule

bind intr_entry_seq intr_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .ack_valid (ack_valid),
    .ext_level (ext_level),
    .lat_valid (lat_valid),
    .lat_level (lat_level),
    .sr        (sr),
    .sp        (sp),
    .cycles    (cycles)
);

// File: tb/tb_intr_entry_seq.sv
module tb_intr_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ext_level = '0;
    logic        int_req = 1'b0;
    logic [3:0]  int_level = '0;
    logic [7:0]  int_vector = '0;
    logic        ack_valid;
    logic [3:0]  ack_level;
    logic [7:0]  ack_vector = '0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready;
    logic        sr_we = 1'b0, vbr_we = 1'b0;
    logic [31:0] sr_wdata = '0, vbr_wdata = '0;
    logic [31:0] pc, sp, sr, vbr, cycles;
    logic        busy;

    always #2 clk = ~clk;

    intr_entry_seq dut (
        .clk(clk), .rst(rst), .ext_level(ext_level), .int_req(int_req),
        .int_level(int_level), .int_vector(int_vector), .ack_valid(ack_valid),
        .ack_level(ack_level), .ack_vector(ack_vector), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .sr_we(sr_we),
        .sr_wdata(sr_wdata), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
        .pc(pc), .sp(sp), .sr(sr), .vbr(vbr), .cycles(cycles), .busy(busy)
    );

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return a * 32'h0001_0003 + 32'h0800_0000;
    endfunction

    bit stall = 1'b0;
    int cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;
    assign mem_ready = !stall || (cyc % 3 == 0);
    assign mem_rdata = mem_fn(mem_addr);

    int          wcnt = 0;
    logic [31:0] w_prev_a, w_prev_d, w_last_a, w_last_d;
    always @(posedge clk) if (!rst && mem_valid && mem_ready && mem_write) begin
        w_prev_a <= w_last_a; w_prev_d <= w_last_d;
        w_last_a <= mem_addr; w_last_d <= mem_wdata;
        wcnt     <= wcnt + 1;
    end

    int         ack_cnt = 0;
    logic [3:0] ack_lvl_seen;
    always @(posedge clk) if (ack_valid) begin
        ack_cnt      <= ack_cnt + 1;
        ack_lvl_seen <= ack_level;
    end

    int checks = 0, fails = 0;
    bit reported = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 200 && busy; n++) tick();
    endtask

    task automatic set_mask(input logic [3:0] m);
        sr_we = 1'b1; sr_wdata = {24'h001234, m, 4'h9};
        tick();
        sr_we = 1'b0;
    endtask

    task automatic drain();
        ext_level = '0;
        set_mask(4'h0);
        for (int n = 0; n < 4 && !busy; n++) tick();
        wait_idle();
    endtask

    task automatic run_case(input logic [3:0] mask, input logic [3:0] ext, input bit use_int,
                            input logic [3:0] ilvl, input logic [7:0] ivec,
                            input logic [7:0] avec, input logic [31:0] base);
        logic [31:0] sr_set, sp0, pc0, cyc0, vec_a;
        logic [3:0]  lvl;
        bit          exp_int, exp_take, taken;
        int          w0, a0;
        exp_int  = use_int && (ilvl >= ext);
        lvl      = exp_int ? ilvl : ext;
        exp_take = lvl > mask;
        sr_set   = {24'h001234, mask, 4'h9};
        ext_level = '0;
        sr_we = 1'b1; sr_wdata = sr_set;
        vbr_we = 1'b1; vbr_wdata = base;
        ack_vector = avec;
        int_req = use_int; int_level = ilvl; int_vector = ivec;
        tick();
        sr_we = 1'b0; vbr_we = 1'b0; int_req = 1'b0;
        sp0 = sp; pc0 = pc; cyc0 = cycles; w0 = wcnt; a0 = ack_cnt;
        ext_level = ext;
        tick();
        for (int n = 0; n < 3 && !busy; n++) tick();
        taken = busy;
        wait_idle();
        ext_level = '0;
        chk(taken == exp_take, "R3 R4 entry started", 32'(taken), 32'(exp_take));
        if (exp_take && taken) begin
            vec_a = base + 32'(exp_int ? ivec : avec) * 4;
            chk(wcnt - w0 == 2, "R7 push count", 32'(wcnt - w0), 32'd2);
            chk(w_prev_a == sp0 - 4 && w_prev_d == sr_set, "R7 first push SR", w_prev_a, sp0 - 4);
            chk(w_last_a == sp0 - 8 && w_last_d == pc0, "R7 second push PC", w_last_a, sp0 - 8);
            chk(sp == sp0 - 8, "R7 final sp", sp, sp0 - 8);
            chk(sr == {sr_set[31:8], lvl, sr_set[3:0]}, "R8 mask raised", sr, {sr_set[31:8], lvl, sr_set[3:0]});
            chk(pc == mem_fn(vec_a), "R9 handler pc", pc, mem_fn(vec_a));
            chk(cycles == cyc0 + 13, "R10 cycle cost", cycles, cyc0 + 13);
            chk(ack_cnt - a0 == (exp_int ? 0 : 1), "R4 R6 ack count", 32'(ack_cnt - a0), exp_int ? 32'd0 : 32'd1);
            if (!exp_int) chk(ack_lvl_seen == lvl, "R6 ack level", 32'(ack_lvl_seen), 32'(lvl));
        end else begin
            chk(pc == pc0 && sp == sp0, "R3 no entry state kept", pc, pc0);
        end
        if (use_int && !(exp_take && exp_int)) drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) tick();
        // R2: reset values
        chk(sr == 32'h0000_00F0, "R2 sr reset", sr, 32'hF0);
        chk(vbr == 0 && cycles == 0, "R2 vbr/cycles reset", vbr | cycles, 0);
        rst = 1'b0;
        // R1: boot PC read comes first
        chk(mem_valid && !mem_write && mem_addr == 0, "R1 boot read addr", mem_addr, 0);
        chk(busy, "R1 busy during boot", 32'(busy), 1);
        wait_idle();
        chk(pc == mem_fn(0), "R1 boot pc", pc, mem_fn(0));
        chk(sp == mem_fn(4), "R1 boot sp", sp, mem_fn(4));

        // R3/R6/R7..R10: external-only sweep, odd masks with a stalling memory (R11)
        for (int m = 0; m < 16; m++)
            for (int e = 0; e < 16; e++) begin
                stall = m[0];
                run_case(4'(m), 4'(e), 1'b0, 4'h0, 8'h00, 8'(m * 16 + e), 32'h4000 + 32'(m) * 32'h100);
            end

        // R4/R5: internal against external, including ties
        for (int m = 0; m < 16; m++)
            for (int e = 0; e < 16; e++)
                for (int k = 0; k < 3; k++) begin
                    stall = (k == 1);
                    run_case(4'(m), 4'(e), 1'b1, (k == 0) ? 4'h1 : (k == 1) ? 4'h7 : 4'hF,
                             8'(255 - m * 16 - e), 8'(m + e), 32'h9000 + 32'(e) * 32'h40);
                end
        stall = 1'b0;

        // R5: captured request persists under a high mask, taken when mask drops
        begin
            logic [31:0] pc0;
            set_mask(4'hF);
            vbr_we = 1'b1; vbr_wdata = 32'h0002_0000;
            int_req = 1'b1; int_level = 4'h6; int_vector = 8'h2C;
            tick();
            vbr_we = 1'b0; int_req = 1'b0;
            pc0 = pc;
            repeat (10) tick();
            chk(!busy && pc == pc0, "R5 held request waits", pc, pc0);
            set_mask(4'h2);
            for (int n = 0; n < 4 && !busy; n++) tick();
            wait_idle();
            chk(pc == mem_fn(32'h0002_0000 + 32'h2C * 4), "R5 held vector used", pc, mem_fn(32'h0002_00B0));
            chk(sr[7:4] == 4'h6, "R5 held level taken", 32'(sr[7:4]), 6);
            pc0 = pc;
            set_mask(4'h0);
            repeat (5) tick();
            chk(!busy && pc == pc0, "R5 capture cleared on accept", pc, pc0);
        end

        // R5/R12: strobes during an entry are ignored
        begin
            logic [31:0] vbr0, sr_exp, pc0;
            vbr0 = vbr;
            sr_exp = {24'h001234, 4'h3, 4'h9};
            stall = 1'b1;
            ext_level = 4'h3; ack_vector = 8'h05;
            for (int n = 0; n < 4 && !busy; n++) tick();
            ext_level = '0;
            int_req = 1'b1; int_level = 4'hC; int_vector = 8'h11;
            sr_we = 1'b1; sr_wdata = 32'hFFFF_FFFF;
            vbr_we = 1'b1; vbr_wdata = 32'hDEAD_0000;
            tick();
            int_req = 1'b0; sr_we = 1'b0; vbr_we = 1'b0;
            wait_idle();
            stall = 1'b0;
            chk(sr == sr_exp, "R12 sr write ignored when busy", sr, sr_exp);
            chk(vbr == vbr0, "R12 vbr write ignored when busy", vbr, vbr0);
            chk(pc == mem_fn(vbr0 + 32'h14), "R11 R9 stalled entry pc", pc, mem_fn(vbr0 + 32'h14));
            pc0 = pc;
            set_mask(4'h0);
            repeat (6) tick();
            chk(!busy && pc == pc0, "R5 int_req ignored when busy", pc, pc0);
        end

        report();
    end
endmodule